// File: doc/BRIEF.md
# Speculative Bundled-Data Completion Generator

This block produces the completion strobe for a single-rail function block whose data travels one wire per bit. The strobe goes high only after a matched delay has passed, and that delay is counted in clock cycles. The matched delays form a bank of cycle counts. An index register picks one entry of the bank through a multiplexer. Every operation starts on the shortest entry. Each time an entry runs out, the block samples a data-dependent hint. If the hint says the operation needs more time, counting moves on to the next longer entry. Otherwise the strobe is raised.

The requester and the block follow a four-phase handshake. The requester raises its request. The block raises done once the selected delay has passed. The requester then lowers the request, and done returns low on the next edge. A second index output tells which bank entry the operation finished on. The last entry must be longer than the slowest path of the function block, so it always covers the worst case.

Top module: `spec_done_gen`

## Requirements
- R1: A synchronous active-high `rst` forces `doneOut` low and `usedIdx` to 0, and abandons any operation in progress.
- R2: With `doneOut` low, a clock edge that samples `reqIn` high accepts an operation. If the hint is low when entry 0 expires, `doneOut` rises exactly `STAGE_LEN[0]` edges after the accepting edge.
- R3: `moreTime` is sampled on the edge where the current entry expires. If it is high there and a longer entry exists, counting continues through the next entry. The latency then becomes the sum of the entries used (defaults 2, 4, 7, 12, so the sums are 2, 6, 13 and 25).
- R4: When the last entry expires, `moreTime` is ignored and `doneOut` rises.
- R5: `doneOut` stays high while `reqIn` is high, and falls on the first edge that samples `reqIn` low.
- R6: While `doneOut` is high, a high `reqIn` starts no new operation. The next operation is accepted only after `doneOut` has returned low.
- R7: From the rise of `doneOut` until the next operation is accepted, `usedIdx` holds the index of the entry the operation finished on. Acceptance resets it to 0.
- R8: `moreTime` has no effect on any edge other than an expiry edge.
- R9: Lowering `reqIn` during counting does not abort the operation. `doneOut` still rises at the computed edge, then falls one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqIn | input | 1 | Four-phase request from the requester |
| moreTime | input | 1 | Hint that the operation needs a longer delay, sampled at expiry |
| doneOut | output | 1 | Completion strobe, held until the request drops |
| usedIdx | output | $clog2(NUM_STAGES) | Index of the bank entry in effect |

## Verification
Two things can happen on the same edge: an entry expiring and the hint being sampled. The bench drives `moreTime` to the opposite of the intended value on every other edge. Only the expiry edge can therefore steer the outcome, and the bench judges the result from the exact edge at which `doneOut` rises and from `usedIdx`. A second collision is a request that drops in the same cycle in which the delay expires early. The bench judges that case by checking for a single-cycle done pulse.

// File: rtl/spec_done_pkg.sv
package spec_done_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } seqState_t;

  // strobes from the sequencer to the timing datapath
  typedef struct packed {
    logic startOp;  // load entry 0 and its length
    logic stepUp;   // move to next entry and load its length
    logic tick;     // count down one cycle
  } dpCtrl_t;

endpackage

// File: rtl/spec_delay_bank.sv
module spec_delay_bank #(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned STAGE_LEN [NUM_STAGES] = '{2, 4, 7, 12},
  localparam int unsigned IDX_W = $clog2(NUM_STAGES)
) (
  input  logic [IDX_W-1:0] selIdx,
  output logic [CNT_W-1:0] loadVal
);

  logic [CNT_W-1:0] bankVal [NUM_STAGES];

  // each entry is stored as length minus one so a down-count ends on zero
  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_entry
    assign bankVal[g] = CNT_W'(STAGE_LEN[g] - 1);
  end

  always_comb begin
    loadVal = '0;
    for (int i = 0; i < NUM_STAGES; i++) begin
      if (selIdx == IDX_W'(i)) loadVal = bankVal[i];
    end
  end

endmodule

// File: rtl/spec_done_dp.sv
module spec_done_dp
  import spec_done_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned STAGE_LEN [NUM_STAGES] = '{2, 4, 7, 12},
  localparam int unsigned IDX_W = $clog2(NUM_STAGES)
) (
  input  logic             clk,
  input  logic             rst,
  input  dpCtrl_t          ctrl,
  output logic             expired,
  output logic             atLast,
  output logic [IDX_W-1:0] curIdx
);

  logic [CNT_W-1:0] remain;
  logic [IDX_W-1:0] bankSel;
  logic [CNT_W-1:0] bankLoad;

  assign bankSel = ctrl.startOp ? '0 : IDX_W'(curIdx + 1'b1);

  spec_delay_bank #(
    .NUM_STAGES(NUM_STAGES),
    .CNT_W     (CNT_W),
    .STAGE_LEN (STAGE_LEN)
  ) u_bank (
    .selIdx (bankSel),
    .loadVal(bankLoad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      curIdx <= '0;
    end else if (ctrl.startOp) begin
      remain <= bankLoad;
      curIdx <= '0;
    end else if (ctrl.stepUp) begin
      remain <= bankLoad;
      curIdx <= bankSel;
    end else if (ctrl.tick) begin
      remain <= remain - 1'b1;
    end
  end

  assign expired = (remain == '0);
  assign atLast  = (curIdx == IDX_W'(NUM_STAGES - 1));

endmodule

// File: rtl/spec_done_ctrl.sv
module spec_done_ctrl
  import spec_done_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    reqIn,
  input  logic    moreTime,
  input  logic    expired,
  input  logic    atLast,
  output dpCtrl_t ctrl,
  output logic    doneOut
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext    = state;
    ctrl.startOp = 1'b0;
    ctrl.stepUp  = 1'b0;
    ctrl.tick    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqIn) begin
          ctrl.startOp = 1'b1;
          stateNext    = ST_RUN;
        end
      end
      ST_RUN: begin
        if (!expired) begin
          ctrl.tick = 1'b1;
        end else if (moreTime && !atLast) begin
          ctrl.stepUp = 1'b1;
        end else begin
          stateNext = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (!reqIn) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign doneOut = (state == ST_HOLD);

endmodule

// File: rtl/spec_done_gen.sv
module spec_done_gen
  import spec_done_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned STAGE_LEN [NUM_STAGES] = '{2, 4, 7, 12},
  localparam int unsigned IDX_W = $clog2(NUM_STAGES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqIn,
  input  logic             moreTime,
  output logic             doneOut,
  output logic [IDX_W-1:0] usedIdx
);

  dpCtrl_t ctrl;
  logic    expired;
  logic    atLast;

  spec_done_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .reqIn   (reqIn),
    .moreTime(moreTime),
    .expired (expired),
    .atLast  (atLast),
    .ctrl    (ctrl),
    .doneOut (doneOut)
  );

  spec_done_dp #(
    .NUM_STAGES(NUM_STAGES),
    .CNT_W     (CNT_W),
    .STAGE_LEN (STAGE_LEN)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctrl   (ctrl),
    .expired(expired),
    .atLast (atLast),
    .curIdx (usedIdx)
  );

endmodule

// File: rtl/spec_done_gen_chk.sv
module spec_done_gen_chk #(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned IDX_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             reqIn,
  input logic             moreTime,
  input logic             doneOut,
  input logic [IDX_W-1:0] usedIdx
);

  // R5: done only falls after the request was seen low
  assert_done_fall_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(doneOut) |-> !$past(reqIn));

  // R6: a held request keeps done high, no restart
  assert_no_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (doneOut && reqIn) |=> doneOut);

  // R3 / R8: the index climbs only on an edge that sampled the hint high
  assert_step_needs_hint_R3: assert property (@(posedge clk) disable iff (rst)
    (usedIdx > $past(usedIdx)) |-> $past(moreTime));

  // R4: completion with the hint high happens only on the last entry
  assert_finish_last_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(doneOut) && $past(moreTime)) |-> (usedIdx == IDX_W'(NUM_STAGES - 1)));

  // R7: index is frozen while done is held
  assert_idx_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (doneOut && $past(doneOut)) |-> $stable(usedIdx));

endmodule

bind spec_done_gen spec_done_gen_chk #(
  .NUM_STAGES(NUM_STAGES),
  .IDX_W     (IDX_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .reqIn   (reqIn),
  .moreTime(moreTime),
  .doneOut (doneOut),
  .usedIdx (usedIdx)
);

// File: tb/spec_done_gen_tb.sv
module spec_done_gen_tb;

  localparam int NS = 4;
  localparam int LEN [NS] = '{2, 4, 7, 12};

  // {hint mask per entry (bit k = hint at expiry of entry k), expected index, expected latency}
  localparam logic [13:0] VECS [7] = '{
    {4'b0000, 2'd0, 8'd2},
    {4'b0001, 2'd1, 8'd6},
    {4'b0011, 2'd2, 8'd13},
    {4'b0111, 2'd3, 8'd25},
    {4'b1111, 2'd3, 8'd25},
    {4'b0010, 2'd0, 8'd2},
    {4'b0101, 2'd1, 8'd6}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reqIn = 1'b0;
  logic       moreTime = 1'b0;
  logic       doneOut;
  logic [1:0] usedIdx;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spec_done_gen u_dut (
    .clk     (clk),
    .rst     (rst),
    .reqIn   (reqIn),
    .moreTime(moreTime),
    .doneOut (doneOut),
    .usedIdx (usedIdx)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runVec(input logic [3:0] mask, input int expIdx, input int expLat);
    int stage = 0;
    int cum = LEN[0];
    @(negedge clk);
    reqIn = 1'b1;
    moreTime = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(!doneOut, "R2 done low after accept", int'(doneOut), 0);
    check(usedIdx == 2'd0, "R7 index cleared on accept", int'(usedIdx), 0);
    for (int t = 1; t <= expLat; t++) begin
      // off-expiry edges get the inverted hint (R8)
      moreTime = (t == cum) ? mask[stage] : ~mask[stage];
      @(posedge clk);
      if (t == cum && mask[stage] && stage < NS - 1) begin
        stage++;
        cum += LEN[stage];
      end
      @(negedge clk);
      if (t < expLat) check(!doneOut, "R3 done early", int'(doneOut), 0);
      else            check(doneOut, "R2 R3 R4 done at latency", int'(doneOut), 1);
    end
    check(usedIdx == 2'(expIdx), "R7 final index", int'(usedIdx), expIdx);
    for (int h = 0; h < 3; h++) begin
      moreTime = h[0];
      @(posedge clk);
      @(negedge clk);
      check(doneOut, "R6 done held with req high", int'(doneOut), 1);
      check(usedIdx == 2'(expIdx), "R7 index held", int'(usedIdx), expIdx);
    end
    reqIn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(!doneOut, "R5 done falls after req low", int'(doneOut), 0);
    check(usedIdx == 2'(expIdx), "R7 index kept after done", int'(usedIdx), expIdx);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!doneOut, "R1 reset done", int'(doneOut), 0);
    check(usedIdx == 2'd0, "R1 reset index", int'(usedIdx), 0);
    rst = 1'b0;

    for (int v = 0; v < 7; v++) begin
      runVec(VECS[v][13:10], int'(VECS[v][9:8]), int'(VECS[v][7:0]));
    end

    // R9: request dropped mid-count, done still comes, one cycle wide
    @(negedge clk);
    reqIn = 1'b1;
    moreTime = 1'b0;
    @(posedge clk);
    @(negedge clk);
    reqIn = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(!doneOut, "R9 not yet done", int'(doneOut), 0);
    @(posedge clk);
    @(negedge clk);
    check(doneOut, "R9 done despite dropped req", int'(doneOut), 1);
    @(posedge clk);
    @(negedge clk);
    check(!doneOut, "R9 done one cycle only", int'(doneOut), 0);

    // R1: reset mid-operation after stepping to entry 1
    reqIn = 1'b1;
    moreTime = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(usedIdx == 2'd1, "R3 stepped before reset", int'(usedIdx), 1);
    rst = 1'b1;
    reqIn = 1'b0;
    moreTime = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(!doneOut, "R1 reset mid-op done", int'(doneOut), 0);
    check(usedIdx == 2'd0, "R1 reset mid-op index", int'(usedIdx), 0);
    rst = 1'b0;
    repeat (30) @(posedge clk);
    @(negedge clk);
    check(!doneOut, "R1 no done after abandoned op", int'(doneOut), 0);

    // R6: back-to-back request accepted only after done falls
    runVec(4'b0000, 0, 2);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule